// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a memory-mapped watchdog. Software reaches it through a simple single-cycle register port with an address, write data, a write strobe, a read strobe and registered read data. A free-running up-counter advances on a slow tick-enable input, optionally through a power-of-two prescaler. When the counter rolls over from all ones, the block raises a reset request for one clock and restarts counting from the programmed load value.

The counter can be started or halted only by writing two particular words, in the right order, to a key register. It is refreshed by writing a trigger register with a value that differs from the previous trigger value. Writes to the control, load, trigger and key registers are posted. Each has its own pending flag in a status register, and the new value takes effect when that flag clears. Software polls the flag before it issues the next write to the same register.

Top module: `keyseq_watchdog`

## Requirements
- R1: Address 0 reads 0x31 in bits 7:0 and zero above. Address 1 holds an idle-enable flag in bit 0 that software can read and write; the write takes effect at once, and the other bits read zero.
- R2: After reset the counter (address 4) reads 0, the counter is halted, the load value is 0, the last trigger value is 0, the prescaler is off, and no reset request is raised.
- R3: A write to control (address 3), load (5), trigger (6) or key (7) sets a pending bit in the status register (address 2). These are bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for key. The bit stays set for PEND_CYC clocks and then clears. The written value takes effect on the clock at which the bit clears. Status bit 1 and bits 31:5 always read 0.
- R4: Committing 0xBBBB to the key register and then committing 0x4444 starts the counter.
- R5: Committing 0xAAAA to the key register and then committing 0x5555 halts the counter.
- R6: A broken key pair, where the second word is not the partner of the armed first word, is discarded and leaves the running state unchanged.
- R7: While running, the counter advances by one on each advance event. While halted it holds its value whatever the tick input does.
- R8: Control bit 5 enables the prescaler and bits 4:2 hold the ratio N. With the prescaler on, the counter advances once every 2^N ticks. With it off, the counter advances on every tick. Reads of the control register return the committed value.
- R9: A committed trigger value that differs from the previous trigger value reloads the counter from the load register and restarts the prescaler. A trigger write equal to the previous value has no effect on the counter.
- R10: An advance from all ones raises the reset request for exactly one clock and reloads the counter from the load register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Slow timer tick, one clock wide per tick |
| busAddr | input | 3 | Register word address |
| busWrData | input | 32 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, registered one clock after the read strobe |
| resetReq | output | 1 | One-clock reset request on counter overflow |

## Verification
The assertions assume that software never writes a posted register again while its pending bit is still set. They also assume that a load write never commits on the same clock as a trigger-driven reload, since that pairing would leave the reload value open to interpretation. The stimulus follows the polling discipline: after every posted write it idles for more than PEND_CYC clocks before touching that register again. Ticks are driven only between register accesses, so every counter value that is read back can be computed exactly from the tick count and the prescaler setting.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int ADDR_W  = 3;
  localparam int RATIO_W = 3;
  localparam int NPOST   = 4;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_REV  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd5;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd6;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd7;

  // posted register slots
  localparam int P_CTRL = 0;
  localparam int P_LOAD = 1;
  localparam int P_TRIG = 2;
  localparam int P_KEY  = 3;

  localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN_B  = 16'h4444;
  localparam logic [15:0] KEY_HALT_A = 16'hAAAA;
  localparam logic [15:0] KEY_HALT_B = 16'h5555;

  typedef enum logic [1:0] {ARM_NONE, ARM_RUN, ARM_HALT} keyArm_t;

  typedef struct packed {
    logic               reload;
    logic               run;
    logic               psEn;
    logic [RATIO_W-1:0] psRatio;
  } dpCtl_t;

  function automatic logic [ADDR_W-1:0] postAddr(input int slot);
    case (slot)
      P_CTRL:  return A_CTRL;
      P_LOAD:  return A_LOAD;
      P_TRIG:  return A_TRIG;
      default: return A_KEY;
    endcase
  endfunction

endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int PEND_CYC = 2,
  parameter logic [7:0] REV_CODE = 8'h31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [DATA_W-1:0] busRdData,
  output logic [CNT_W-1:0]  loadVal,
  output dpCtl_t            dpCtl
);

  localparam int PC_W = $clog2(PEND_CYC + 1);

  logic [NPOST-1:0]  hit, commit, pendBit;
  logic [DATA_W-1:0] shadow [NPOST];
  logic [PC_W-1:0]   pendCnt [NPOST];

  logic               runQ, psEnQ, cfgIdle;
  logic [RATIO_W-1:0] ratioQ;
  logic [DATA_W-1:0]  lastTrig, lastKey;
  keyArm_t            keyArm;
  logic [15:0]        keyWord;

  // one posted-write tracker per posted register
  for (genvar g = 0; g < NPOST; g++) begin : gPost
    assign hit[g]     = busWr && (busAddr == postAddr(g));
    assign pendBit[g] = (pendCnt[g] != '0);
    assign commit[g]  = (pendCnt[g] == PC_W'(1)) && !hit[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendCnt[g] <= '0;
        shadow[g]  <= '0;
      end else if (hit[g]) begin
        pendCnt[g] <= PC_W'(PEND_CYC);
        shadow[g]  <= busWrData;
      end else if (pendBit[g]) begin
        pendCnt[g] <= pendCnt[g] - PC_W'(1);
      end
    end
  end

  assign keyWord = shadow[P_KEY][15:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      psEnQ    <= 1'b0;
      ratioQ   <= '0;
      loadVal  <= '0;
      lastTrig <= '0;
      lastKey  <= '0;
      keyArm   <= ARM_NONE;
      cfgIdle  <= 1'b0;
    end else begin
      if (busWr && busAddr == A_CFG) cfgIdle <= busWrData[0];
      if (commit[P_CTRL]) begin
        psEnQ  <= shadow[P_CTRL][5];
        ratioQ <= shadow[P_CTRL][4:2];
      end
      if (commit[P_LOAD]) loadVal  <= shadow[P_LOAD][CNT_W-1:0];
      if (commit[P_TRIG]) lastTrig <= shadow[P_TRIG];
      if (commit[P_KEY]) begin
        lastKey <= shadow[P_KEY];
        if (shadow[P_KEY] == DATA_W'(KEY_RUN_A))
          keyArm <= ARM_RUN;
        else if (shadow[P_KEY] == DATA_W'(KEY_HALT_A))
          keyArm <= ARM_HALT;
        else begin
          keyArm <= ARM_NONE;
          if (keyArm == ARM_RUN && keyWord == KEY_RUN_B && shadow[P_KEY] == DATA_W'(keyWord))
            runQ <= 1'b1;
          else if (keyArm == ARM_HALT && keyWord == KEY_HALT_B && shadow[P_KEY] == DATA_W'(keyWord))
            runQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    dpCtl.reload  = commit[P_TRIG] && (shadow[P_TRIG] != lastTrig);
    dpCtl.run     = runQ;
    dpCtl.psEn    = psEnQ;
    dpCtl.psRatio = ratioQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else if (busRd) begin
      case (busAddr)
        A_REV:   busRdData <= DATA_W'(REV_CODE);
        A_CFG:   busRdData <= DATA_W'(cfgIdle);
        A_STAT:  busRdData <= DATA_W'({pendBit[P_KEY], pendBit[P_TRIG], pendBit[P_LOAD], 1'b0, pendBit[P_CTRL]});
        A_CTRL:  busRdData <= DATA_W'({psEnQ, ratioQ, 2'b00});
        A_CNT:   busRdData <= DATA_W'(cntVal);
        A_LOAD:  busRdData <= DATA_W'(loadVal);
        A_TRIG:  busRdData <= lastTrig;
        default: busRdData <= lastKey;
      endcase
    end
  end

endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dpCtl_t           dpCtl,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             resetReq
);

  localparam int PS_W = (1 << RATIO_W) - 1;

  logic [PS_W-1:0] psCnt, psLim;
  logic            stepTick, advance, atTop;

  assign psLim    = PS_W'((PS_W+1)'(1) << dpCtl.psRatio) - PS_W'(1);
  assign stepTick = tickEn && dpCtl.run;
  assign advance  = stepTick && (!dpCtl.psEn || psCnt == psLim);
  assign atTop    = (cntVal == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt    <= '0;
      cntVal   <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      if (dpCtl.reload) begin
        cntVal <= loadVal;
        psCnt  <= '0;
      end else begin
        if (stepTick && dpCtl.psEn)
          psCnt <= (psCnt == psLim) ? '0 : psCnt + PS_W'(1);
        if (advance) begin
          if (atTop) begin
            cntVal   <= loadVal;
            resetReq <= 1'b1;
          end else begin
            cntVal <= cntVal + CNT_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/keyseq_watchdog.sv
module keyseq_watchdog
  import kwd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int PEND_CYC = 2,
  parameter logic [7:0] REV_CODE = 8'h31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWrData,
  input  logic        busWr,
  input  logic        busRd,
  output logic [31:0] busRdData,
  output logic        resetReq
);

  dpCtl_t           dpCtl;
  logic [CNT_W-1:0] cntVal, loadVal;

  kwd_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PEND_CYC(PEND_CYC), .REV_CODE(REV_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .cntVal(cntVal), .busRdData(busRdData),
    .loadVal(loadVal), .dpCtl(dpCtl)
  );

  kwd_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dpCtl(dpCtl),
    .loadVal(loadVal), .cntVal(cntVal), .resetReq(resetReq)
  );

endmodule

// File: rtl/keyseq_watchdog_chk.sv
module keyseq_watchdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       busAddr,
  input logic             busWr,
  input logic             busRd,
  input logic [31:0]      busRdData,
  input logic             resetReq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] loadVal,
  input logic             dpRun,
  input logic             dpReload
);

  // R7: a halted counter with no reload keeps its value
  a_r7_hold_when_halted: assert property (@(posedge clk) disable iff (!rstN)
    (!dpRun && !dpReload) |=> $stable(cntVal));

  // R9: a reload strobe places the load value in the counter
  a_r9_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    dpReload |=> (cntVal == $past(loadVal)));

  // R10: the reset request follows a counter at all ones and leaves the load value
  a_r10_wrap_reload: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(cntVal) == {CNT_W{1'b1}} && cntVal == $past(loadVal)));

  // R10: a reset request comes only after an active counter
  a_r10_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(dpRun));

  // R3: a load write is reported as pending on the next status read
  a_r3_load_pending: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd5) ##1 (busRd && busAddr == 3'd2) |=> busRdData[2]);

  // R3: unused status bits read zero
  a_r3_status_spare_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd2) |=> (busRdData[1] == 1'b0 && busRdData[31:5] == '0));

endmodule

bind keyseq_watchdog keyseq_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busRdData(busRdData), .resetReq(resetReq), .cntVal(cntVal), .loadVal(loadVal),
  .dpRun(dpCtl.run), .dpReload(dpCtl.reload)
);

// File: tb/keyseq_watchdog_bench.sv
`timescale 1ns/1ps
module keyseq_watchdog_bench;

  localparam int PEND = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busRdData;
  logic        resetReq;

  int testsRun = 0;
  int testsFailed = 0;
  int rstPulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keyseq_watchdog u_keyseq_watchdog (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .busRdData(busRdData), .resetReq(resetReq)
  );

  // ---------------- behavioural reference model ----------------
  int          mPend [4];
  logic [31:0] mShadow [4];
  logic [31:0] mLoad, mLastTrig, mKey, mCnt, mRd;
  logic        mRun, mPsEn, mRst, mCfg;
  int          mRatio, mArm, mPs;

  function automatic int slotAddr(int s);
    case (s) 0: return 3; 1: return 5; 2: return 6; default: return 7; endcase
  endfunction

  function automatic logic [31:0] modelRead(int a);
    case (a)
      0: return 32'h31;
      1: return {31'b0, mCfg};
      2: return {27'b0, mPend[3] != 0, mPend[2] != 0, mPend[1] != 0, 1'b0, mPend[0] != 0};
      3: return {26'b0, mPsEn, 3'(mRatio), 2'b00};
      4: return mCnt;
      5: return mLoad;
      6: return mLastTrig;
      default: return mKey;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mPend[i] = 0; mShadow[i] = 0; end
      mLoad = 0; mLastTrig = 0; mKey = 0; mCnt = 0; mRd = 0;
      mRun = 0; mPsEn = 0; mRst = 0; mCfg = 0; mRatio = 0; mArm = 0; mPs = 0;
    end else begin
      bit cm [4];
      bit rel, adv;
      int lim;
      for (int i = 0; i < 4; i++)
        cm[i] = (mPend[i] == 1) && !(busWr && busAddr == slotAddr(i));
      if (busRd) mRd = modelRead(busAddr);
      // counter side, using values before this edge
      rel = cm[2] && (mShadow[2] != mLastTrig);
      lim = (1 << mRatio) - 1;
      adv = tickEn && mRun && (!mPsEn || mPs == lim);
      mRst = 0;
      if (rel) begin
        mCnt = mLoad; mPs = 0;
      end else if (tickEn && mRun) begin
        if (mPsEn) mPs = (mPs == lim) ? 0 : mPs + 1;
        if (adv) begin
          if (mCnt == 32'hFFFF_FFFF) begin mCnt = mLoad; mRst = 1; end
          else mCnt = mCnt + 1;
        end
      end
      // register side
      if (busWr && busAddr == 1) mCfg = busWrData[0];
      if (cm[0]) begin mPsEn = mShadow[0][5]; mRatio = int'(mShadow[0][4:2]); end
      if (cm[1]) mLoad = mShadow[1];
      if (cm[2]) mLastTrig = mShadow[2];
      if (cm[3]) begin
        mKey = mShadow[3];
        if (mShadow[3] == 32'hBBBB) mArm = 1;
        else if (mShadow[3] == 32'hAAAA) mArm = 2;
        else begin
          if (mArm == 1 && mShadow[3] == 32'h4444) mRun = 1;
          if (mArm == 2 && mShadow[3] == 32'h5555) mRun = 0;
          mArm = 0;
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (busWr && busAddr == slotAddr(i)) begin
          mPend[i] = PEND; mShadow[i] = busWrData;
        end else if (mPend[i] != 0) mPend[i] = mPend[i] - 1;
      end
    end
  end

  // per-clock comparison against the model (R2, R10)
  always @(negedge clk) begin
    if (rstN && !done) begin
      testsRun++;
      if (resetReq !== mRst) begin
        testsFailed++;
        $display("FAIL R10 model resetReq: got %b expected %b", resetReq, mRst);
      end
      testsRun++;
      if (busRdData !== mRd) begin
        testsFailed++;
        $display("FAIL R2 model readback: got %h expected %h", busRdData, mRd);
      end
      if (resetReq === 1'b1) rstPulses++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(int a, logic [31:0] d);
    busAddr = 3'(a); busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrPosted(int a, logic [31:0] d);
    wrReg(a, d);
    idle(PEND + 2);
  endtask

  task automatic rdReg(int a, output logic [31:0] d);
    busAddr = 3'(a); busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic ticks(int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R2: reset state
    check("R2 resetReq after reset", {31'b0, resetReq}, 32'h0);
    rdReg(2, v); check("R2 status after reset", v, 32'h0);
    rdReg(4, v); check("R2 counter after reset", v, 32'h0);

    // R1: revision and config
    rdReg(0, v); check("R1 revision", v, 32'h31);
    wrReg(1, 32'hFF); rdReg(1, v); check("R1 config idle bit", v, 32'h1);
    wrReg(1, 32'h0);  rdReg(1, v); check("R1 config cleared", v, 32'h0);

    // R3: posted load write
    wrReg(5, 32'hFFFF_FFF0);
    rdReg(2, v); check("R3 load pending bit 2", v, 32'h4);
    rdReg(5, v); check("R3 load not yet applied", v, 32'h0);
    idle(2);
    rdReg(2, v); check("R3 load pending cleared", v, 32'h0);
    rdReg(5, v); check("R3 load applied", v, 32'hFFFF_FFF0);
    wrReg(3, 32'h0); rdReg(2, v); check("R3 control pending bit 0", v, 32'h1);
    idle(3);
    wrReg(7, 32'h0); rdReg(2, v); check("R3 key pending bit 4", v, 32'h10);
    idle(3);

    // R7: halted counter ignores ticks
    ticks(5); rdReg(4, v); check("R7 halted ignores ticks", v, 32'h0);

    // R4: start, R9 reload
    wrPosted(7, 32'hBBBB); wrPosted(7, 32'h4444);
    wrReg(6, 32'h1); rdReg(2, v); check("R3 trigger pending bit 3", v, 32'h8);
    idle(3);
    rdReg(4, v); check("R9 reload from load", v, 32'hFFFF_FFF0);
    ticks(5); rdReg(4, v); check("R4 running after key pair", v, 32'hFFFF_FFF5);
    wrPosted(6, 32'h1); rdReg(4, v); check("R9 same trigger ignored", v, 32'hFFFF_FFF5);

    // R10: overflow
    rstPulses = 0;
    ticks(10); rdReg(4, v); check("R7 counting to top", v, 32'hFFFF_FFFF);
    check("R10 no request before wrap", rstPulses, 0);
    ticks(1); idle(2);
    check("R10 single-cycle request", rstPulses, 1);
    rdReg(4, v); check("R10 reload on wrap", v, 32'hFFFF_FFF0);

    // R5: stop
    wrPosted(7, 32'hAAAA); wrPosted(7, 32'h5555);
    ticks(5); rdReg(4, v); check("R5 halted by key pair", v, 32'hFFFF_FFF0);

    // R6: broken sequences
    wrPosted(7, 32'hBBBB); wrPosted(7, 32'h5555);
    ticks(4); rdReg(4, v); check("R6 broken start discarded", v, 32'hFFFF_FFF0);
    wrPosted(7, 32'hBBBB); wrPosted(7, 32'h4444);
    ticks(2); rdReg(4, v); check("R4 restart", v, 32'hFFFF_FFF2);
    wrPosted(7, 32'hAAAA); wrPosted(7, 32'h4444);
    ticks(3); rdReg(4, v); check("R6 broken stop discarded", v, 32'hFFFF_FFF5);
    rdReg(7, v); check("R6 last key word", v, 32'h4444);

    // R8: prescaler ratio 2 -> every 4 ticks
    wrPosted(3, 32'h28); rdReg(3, v); check("R8 control readback", v, 32'h28);
    wrPosted(6, 32'h2); rdReg(4, v); check("R9 new trigger reload", v, 32'hFFFF_FFF0);
    ticks(8); rdReg(4, v); check("R8 two advances in eight ticks", v, 32'hFFFF_FFF2);
    ticks(3); rdReg(4, v); check("R8 no advance before period", v, 32'hFFFF_FFF2);
    ticks(1); rdReg(4, v); check("R8 advance at period end", v, 32'hFFFF_FFF3);
    wrPosted(3, 32'h0);
    ticks(2); rdReg(4, v); check("R8 prescaler off", v, 32'hFFFF_FFF5);

    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule